// File: doc/BRIEF.md
# Shared-Bus Memory Stall Sequencer

This block is the control sequencer for the memory-access instructions of a small pipelined processor. Instruction fetches and data accesses go through one memory address bus and one data bus. It looks at the opcode held in the instruction register during decode and keeps a short internal phase. From these it drives, on every cycle, the strobes that the surrounding datapath needs. These are: load or synchronously clear the instruction register, increment or load the instruction address register, load the memory address register, load the data register (from memory or from a register operand), write memory, and select which address drives the shared bus. It also issues a register-file write of the data register two cycles after a load instruction is decoded. That write targets the destination field captured when the load was decoded.

A stall is inserted by clearing the instruction register to the no-operation encoding (opcode 0). The pipeline then carries a bubble while the bus is used for data. Loads and stores take one extra stalled cycle after decode. The datapath itself (ALU, register file, forwarding) lies outside this block. All pins are plain control pins. There is no streaming data at this block's edge, so no valid/ready handshake and no back-pressure applies.

Top module: `shbus_stall_seq`

## Requirements
- R1: With the phase idle, opcodes 0 and 4 to 7, and the unused codes 11 to 15, give a plain fetch: `ir_load` and `iar_inc` high, every other strobe low, and `bus_sel_data` low (instruction address on the bus).
- R2: Opcode 1 (load immediate) in decode gives `ir_clr`, `iar_inc`, `dr_load` and `dr_from_mem`, with the bus on the instruction address. The following cycle asserts only `ir_clr`.
- R3: Opcode 2 (load) in decode gives `mar_load` and `ir_clr`. The following cycle gives `ir_clr`, `dr_load`, `dr_from_mem` and `bus_sel_data`.
- R4: Opcode 3 (store) in decode gives `mar_load`, `dr_load` with `dr_from_mem` low (register source), and `ir_clr`. The following cycle gives `ir_clr`, `mem_we` and `bus_sel_data`.
- R5: Each cycle asserts exactly one of `ir_load` and `ir_clr`. `iar_inc` accompanies `ir_clr` only on the immediate-byte read of R2. `bus_sel_data` is high only on stall cycles.
- R6: Opcode 8 (jump) gives `ir_load` and `iar_load`, with `iar_inc` low, so the delay-slot instruction is still fetched.
- R7: Opcode 9 asserts `iar_load` when `flag_z` is high, and opcode 10 does so when `flag_n` is high. Otherwise `iar_inc` is asserted. In both cases `ir_load` is high.
- R8: `rf_we` pulses exactly two cycles after the decode cycle of a load immediate or a load, with `rf_waddr` equal to the `dec_rd` value at that decode cycle. A store never causes it. `rf_waddr` reads 0 whenever `rf_we` is low.
- R9: During the follow-on cycle of a load immediate, load or store, `dec_op` and `dec_rd` have no effect on any output.
- R10: Reset returns the phase to idle and cancels any pending register-file write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_op | input | OP_W | Opcode in the decode stage |
| dec_rd | input | RD_W | Destination field in the decode stage |
| flag_z | input | 1 | Zero status flag |
| flag_n | input | 1 | Negative status flag |
| ir_load | output | 1 | Load instruction register from the bus |
| ir_clr | output | 1 | Synchronously clear instruction register (stall) |
| iar_inc | output | 1 | Increment instruction address |
| iar_load | output | 1 | Load instruction address from register operand |
| mar_load | output | 1 | Load memory address register |
| dr_load | output | 1 | Load data register |
| dr_from_mem | output | 1 | Data register source: 1 memory bus, 0 register operand |
| mem_we | output | 1 | Memory write of data register |
| bus_sel_data | output | 1 | Bus address: 1 memory address register, 0 instruction address |
| rf_we | output | 1 | Register-file write of the data register |
| rf_waddr | output | RD_W | Register-file write address |

## Verification
The bench builds the block with its default parameters: a 4-bit opcode, a 2-bit destination field and a two-stage write-back delay. With these, all four destination values can be checked to appear on the delayed write port. A load can be decoded in the very cycle a previous load immediate retires its write, which tests the overlap. Garbage opcodes are driven during follow-on stall cycles to show that they are ignored. A reset in the middle of a load immediate confirms that its write never lands.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_NOP = 4'h0;
  localparam logic [OPC_W-1:0] OPC_LDI = 4'h1;
  localparam logic [OPC_W-1:0] OPC_LD  = 4'h2;
  localparam logic [OPC_W-1:0] OPC_ST  = 4'h3;
  localparam logic [OPC_W-1:0] OPC_JMP = 4'h8;
  localparam logic [OPC_W-1:0] OPC_BRZ = 4'h9;
  localparam logic [OPC_W-1:0] OPC_BRN = 4'hA;

  // instruction class seen by the sequencer
  typedef enum logic [2:0] {
    CL_FETCH,
    CL_LDI,
    CL_LD,
    CL_ST,
    CL_JUMP,
    CL_BRZ,
    CL_BRN
  } cls_e;

  // sequencer phase: idle or the follow-on cycle of a memory op
  typedef enum logic [1:0] {
    PH_RUN,
    PH_LDI_HOLD,
    PH_LD_READ,
    PH_ST_WRITE
  } phase_e;

  typedef struct packed {
    logic ir_load;
    logic ir_clr;
    logic iar_inc;
    logic iar_load;
    logic mar_load;
    logic dr_load;
    logic dr_from_mem;
    logic mem_we;
    logic bus_data;
    logic wb_start;
  } strobe_t;
endpackage

// File: rtl/sbs_op_decode.sv
module sbs_op_decode
  import sbs_pkg::*;
#(
  parameter int OP_W = OPC_W
) (
  input  logic [OP_W-1:0] op,
  output cls_e            cls
);
  always_comb begin
    case (op)
      OP_W'(OPC_LDI): cls = CL_LDI;
      OP_W'(OPC_LD):  cls = CL_LD;
      OP_W'(OPC_ST):  cls = CL_ST;
      OP_W'(OPC_JMP): cls = CL_JUMP;
      OP_W'(OPC_BRZ): cls = CL_BRZ;
      OP_W'(OPC_BRN): cls = CL_BRN;
      default:        cls = CL_FETCH;
    endcase
  end
endmodule

// File: rtl/sbs_seq_fsm.sv
module sbs_seq_fsm
  import sbs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  cls_e    cls,
  input  logic    flag_z,
  input  logic    flag_n,
  output strobe_t stb
);
  phase_e ph_q, ph_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_RUN;
    else        ph_q <= ph_d;
  end

  always_comb begin
    stb  = '0;
    ph_d = PH_RUN;
    case (ph_q)
      PH_RUN: begin
        case (cls)
          CL_LDI: begin
            stb.ir_clr      = 1'b1;
            stb.iar_inc     = 1'b1;
            stb.dr_load     = 1'b1;
            stb.dr_from_mem = 1'b1;
            stb.wb_start    = 1'b1;
            ph_d            = PH_LDI_HOLD;
          end
          CL_LD: begin
            stb.ir_clr   = 1'b1;
            stb.mar_load = 1'b1;
            stb.wb_start = 1'b1;
            ph_d         = PH_LD_READ;
          end
          CL_ST: begin
            stb.ir_clr   = 1'b1;
            stb.mar_load = 1'b1;
            stb.dr_load  = 1'b1;
            ph_d         = PH_ST_WRITE;
          end
          CL_JUMP: begin
            stb.ir_load  = 1'b1;
            stb.iar_load = 1'b1;
          end
          CL_BRZ: begin
            stb.ir_load  = 1'b1;
            stb.iar_load = flag_z;
            stb.iar_inc  = !flag_z;
          end
          CL_BRN: begin
            stb.ir_load  = 1'b1;
            stb.iar_load = flag_n;
            stb.iar_inc  = !flag_n;
          end
          default: begin
            stb.ir_load = 1'b1;
            stb.iar_inc = 1'b1;
          end
        endcase
      end
      PH_LDI_HOLD: begin
        stb.ir_clr = 1'b1;
      end
      PH_LD_READ: begin
        stb.ir_clr      = 1'b1;
        stb.dr_load     = 1'b1;
        stb.dr_from_mem = 1'b1;
        stb.bus_data    = 1'b1;
      end
      PH_ST_WRITE: begin
        stb.ir_clr   = 1'b1;
        stb.mem_we   = 1'b1;
        stb.bus_data = 1'b1;
      end
      default: begin
        stb.ir_clr = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/sbs_wb_delay.sv
module sbs_wb_delay #(
  parameter int RD_W  = 2,
  parameter int DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [RD_W-1:0] rd_in,
  output logic            we,
  output logic [RD_W-1:0] waddr
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] vld_q;
  logic [RD_W-1:0]  rd_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[0] <= 1'b0;
          rd_q[0]  <= '0;
        end else begin
          vld_q[0] <= start;
          rd_q[0]  <= rd_in;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[g] <= 1'b0;
          rd_q[g]  <= '0;
        end else begin
          vld_q[g] <= vld_q[g-1];
          rd_q[g]  <= rd_q[g-1];
        end
      end
    end
  end

  assign we    = vld_q[LAST];
  assign waddr = vld_q[LAST] ? rd_q[LAST] : '0;
endmodule

// File: rtl/shbus_stall_seq.sv
module shbus_stall_seq
  import sbs_pkg::*;
#(
  parameter int OP_W     = OPC_W,
  parameter int RD_W     = 2,
  parameter int WB_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] dec_op,
  input  logic [RD_W-1:0] dec_rd,
  input  logic            flag_z,
  input  logic            flag_n,
  output logic            ir_load,
  output logic            ir_clr,
  output logic            iar_inc,
  output logic            iar_load,
  output logic            mar_load,
  output logic            dr_load,
  output logic            dr_from_mem,
  output logic            mem_we,
  output logic            bus_sel_data,
  output logic            rf_we,
  output logic [RD_W-1:0] rf_waddr
);
  cls_e    cls;
  strobe_t stb;

  sbs_op_decode #(.OP_W(OP_W)) u_dec (
    .op  (dec_op),
    .cls (cls)
  );

  sbs_seq_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .cls    (cls),
    .flag_z (flag_z),
    .flag_n (flag_n),
    .stb    (stb)
  );

  sbs_wb_delay #(.RD_W(RD_W), .DEPTH(WB_DEPTH)) u_wb (
    .clk   (clk),
    .rst_n (rst_n),
    .start (stb.wb_start),
    .rd_in (dec_rd),
    .we    (rf_we),
    .waddr (rf_waddr)
  );

  assign ir_load      = stb.ir_load;
  assign ir_clr       = stb.ir_clr;
  assign iar_inc      = stb.iar_inc;
  assign iar_load     = stb.iar_load;
  assign mar_load     = stb.mar_load;
  assign dr_load      = stb.dr_load;
  assign dr_from_mem  = stb.dr_from_mem;
  assign mem_we       = stb.mem_we;
  assign bus_sel_data = stb.bus_data;
endmodule

// File: rtl/shbus_stall_seq_chk.sv
module shbus_stall_seq_chk #(
  parameter int RD_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ir_load,
  input logic            ir_clr,
  input logic            iar_inc,
  input logic            iar_load,
  input logic            mar_load,
  input logic            dr_load,
  input logic            dr_from_mem,
  input logic            mem_we,
  input logic            bus_sel_data,
  input logic            rf_we,
  input logic [RD_W-1:0] rf_waddr
);
  AST_ONE_IR_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ir_load, ir_clr}) == 1); // R5
  AST_STALL_INC_IMM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_clr && iar_inc) |-> (dr_load && dr_from_mem && !bus_sel_data)); // R2
  AST_DATA_BUS_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel_data |-> (ir_clr && !iar_inc)); // R5
  AST_IAR_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    iar_load |-> (ir_load && !iar_inc)); // R6
  AST_LD_READ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (mar_load && !dr_load) |=> (dr_load && dr_from_mem && bus_sel_data)); // R3
  AST_ST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (mar_load && dr_load) |=> (mem_we && bus_sel_data)); // R4
  AST_WB_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(ir_clr)); // R8
  AST_WADDR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_we |-> (rf_waddr == '0)); // R8
endmodule

bind shbus_stall_seq shbus_stall_seq_chk #(.RD_W(RD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ir_load      (ir_load),
  .ir_clr       (ir_clr),
  .iar_inc      (iar_inc),
  .iar_load     (iar_load),
  .mar_load     (mar_load),
  .dr_load      (dr_load),
  .dr_from_mem  (dr_from_mem),
  .mem_we       (mem_we),
  .bus_sel_data (bus_sel_data),
  .rf_we        (rf_we),
  .rf_waddr     (rf_waddr)
);

// File: tb/shbus_stall_seq_bench.sv
module shbus_stall_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] dec_op = 4'h0;
  logic [1:0] dec_rd = 2'd0;
  logic       flag_z = 1'b0;
  logic       flag_n = 1'b0;
  logic       ir_load, ir_clr, iar_inc, iar_load, mar_load, dr_load;
  logic       dr_from_mem, mem_we, bus_sel_data, rf_we;
  logic [1:0] rf_waddr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  shbus_stall_seq u_shbus_stall_seq (
    .clk(clk), .rst_n(rst_n), .dec_op(dec_op), .dec_rd(dec_rd),
    .flag_z(flag_z), .flag_n(flag_n),
    .ir_load(ir_load), .ir_clr(ir_clr), .iar_inc(iar_inc),
    .iar_load(iar_load), .mar_load(mar_load), .dr_load(dr_load),
    .dr_from_mem(dr_from_mem), .mem_we(mem_we),
    .bus_sel_data(bus_sel_data), .rf_we(rf_we), .rf_waddr(rf_waddr)
  );

  // expected bits: ir_load ir_clr iar_inc iar_load | mar_load dr_load
  // dr_from_mem mem_we | bus_sel_data rf_we rf_waddr[1:0]
  localparam logic [11:0] S_FETCH = 12'b1010_0000_0000;
  localparam logic [11:0] S_LDIRD = 12'b0110_0110_0000;
  localparam logic [11:0] S_HOLD  = 12'b0100_0000_0000;
  localparam logic [11:0] S_LDA   = 12'b0100_1000_0000;
  localparam logic [11:0] S_LDRD  = 12'b0100_0110_1000;
  localparam logic [11:0] S_STA   = 12'b0100_1100_0000;
  localparam logic [11:0] S_STWR  = 12'b0100_0001_1000;
  localparam logic [11:0] S_JUMP  = 12'b1001_0000_0000;

  // {req, op, rd, z, n, expected}
  localparam int NV = 28;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1,  4'h0, 2'd0, 2'b00, S_FETCH},            // R1 nop
    {4'd1,  4'h5, 2'd1, 2'b00, S_FETCH},            // R1 inc
    {4'd2,  4'h1, 2'd2, 2'b00, S_LDIRD},            // R2 ldi byte read
    {4'd2,  4'h0, 2'd3, 2'b00, S_HOLD},             // R2 ldi hold
    {4'd8,  4'h0, 2'd0, 2'b00, S_FETCH | 12'b110},  // R8 ldi write rd2
    {4'd3,  4'h2, 2'd3, 2'b00, S_LDA},              // R3 ld address
    {4'd3,  4'h0, 2'd1, 2'b00, S_LDRD},             // R3 ld read
    {4'd8,  4'h4, 2'd1, 2'b00, S_FETCH | 12'b111},  // R8 ld write rd3
    {4'd4,  4'h3, 2'd2, 2'b00, S_STA},              // R4 st address+data
    {4'd4,  4'h0, 2'd0, 2'b00, S_STWR},             // R4 st write
    {4'd6,  4'h8, 2'd0, 2'b00, S_JUMP},             // R6 jmp, no wb after st
    {4'd7,  4'h9, 2'd0, 2'b10, S_JUMP},             // R7 brz taken
    {4'd7,  4'h9, 2'd0, 2'b01, S_FETCH},            // R7 brz not taken
    {4'd7,  4'hA, 2'd0, 2'b01, S_JUMP},             // R7 brn taken
    {4'd7,  4'hA, 2'd0, 2'b10, S_FETCH},            // R7 brn not taken
    {4'd1,  4'hF, 2'd2, 2'b00, S_FETCH},            // R1 unused code
    {4'd1,  4'h6, 2'd0, 2'b00, S_FETCH},            // R1 neg
    {4'd1,  4'h7, 2'd3, 2'b00, S_FETCH},            // R1 sub
    {4'd2,  4'h1, 2'd1, 2'b00, S_LDIRD},            // R2 ldi rd1
    {4'd9,  4'h2, 2'd3, 2'b00, S_HOLD},             // R9 ld ignored in hold
    {4'd8,  4'h2, 2'd0, 2'b00, S_LDA | 12'b101},    // R8 ld + ldi write rd1
    {4'd9,  4'h3, 2'd2, 2'b00, S_LDRD},             // R9 st ignored in read
    {4'd8,  4'h0, 2'd1, 2'b00, S_FETCH | 12'b100},  // R8 ld write rd0
    {4'd4,  4'h3, 2'd1, 2'b00, S_STA},              // R4 st
    {4'd9,  4'h1, 2'd3, 2'b00, S_STWR},             // R9 ldi ignored in write
    {4'd8,  4'h0, 2'd0, 2'b00, S_FETCH},            // R8 no write after st
    {4'd7,  4'hA, 2'd0, 2'b00, S_FETCH},            // R7 brn flags low
    {4'd6,  4'h8, 2'd2, 2'b11, S_JUMP}              // R6 jmp ignores flags
  };

  function automatic logic [11:0] observed();
    return {ir_load, ir_clr, iar_inc, iar_load, mar_load, dr_load,
            dr_from_mem, mem_we, bus_sel_data, rf_we, rf_waddr};
  endfunction

  task automatic check(input int req, input logic [11:0] exp, input string what);
    logic [11:0] got;
    got = observed();
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [1:0] rd,
                      input logic z, input logic n);
    @(negedge clk);
    dec_op = op; dec_rd = rd; flag_z = z; flag_n = n;
    #5;
  endtask

  initial begin
    // reset state, R10
    #25;
    check(10, S_FETCH, "during reset");
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    check(10, S_FETCH, "after reset release");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][19:16], VEC[i][15:14], VEC[i][13], VEC[i][12]);
      check(int'(VEC[i][23:20]), VEC[i][11:0], $sformatf("vector %0d", i));
    end

    // R10: reset in the middle of a load immediate cancels its write
    step(4'h1, 2'd3, 1'b0, 1'b0);
    check(2, S_LDIRD, "ldi before reset");
    @(negedge clk);
    rst_n = 1'b0;
    dec_op = 4'h0;
    #5;
    check(10, S_FETCH, "reset mid ldi");
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    check(10, S_FETCH, "no hold after reset");
    step(4'h0, 2'd0, 1'b0, 1'b0);
    check(10, S_FETCH, "no write after reset");
    step(4'h0, 2'd0, 1'b0, 1'b0);
    check(10, S_FETCH, "still no write");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R10 watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule